// File: doc/BRIEF.md
# Double-Buffered Backlight PWM Generator

This block drives one active-high pulse line for display backlight dimming. A prescaler divides the input clock into PWM ticks. A tick counter runs from zero up to a programmed period value and then wraps. The output is high for the first `high` ticks of each period. Software configures the block through a small synchronous register port.

The prescaler and the period/high-width settings are double-buffered. Writes land in shadow registers. A commit strobe moves the shadow contents into the working registers at the next period boundary, so no period is ever cut short. A debug control can bypass the shadowing, and then configuration writes reach the working registers on the next clock. A select bit chooses between the programmed period/high values and fixed parameter defaults.

Top module: `bl_pwm`

## Requirements
- R1: After reset, every register reads 0 and `pwm_o` is low.
- R2: While enabled, one output period lasts (div+1)*(per+1) clocks. `div` is at address 1 bits 25:16 and `per` is at address 2 bits 11:0.
- R3: Each period starts with the output high for (div+1)*hi clocks. `hi` is at address 2 bits 28:16, and hi=0 keeps the output constantly low.
- R4: Bit 0 at address 0 is the enable bit. Writing 1 starts a fresh period: the output is in its high phase from the first clock after the write. Writing 0 forces `pwm_o` low from the next clock.
- R5: Writes to address 1 or 2 leave the output unchanged until a commit is made. A commit is a write that takes bit 0 at address 3 from 0 to 1.
- R6: While running, committed values take effect at the next period boundary, and the current period completes with the old values. While disabled, committed values take effect at once.
- R7: When address 4 bits 1:0 equal 3 (bypass), writes to address 1 and 2 reach the working registers on the next clock, with no commit.
- R8: Bit 1 at address 1 selects the period/high source: 1 uses the programmed values, 0 uses the parameters DFLT_PER and DFLT_HI.
- R9: When hi > per, the output stays high for the whole period.
- R10: A read returns the shadow register contents on `rdata` in the clock after `rd_en` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| pwm_o | output | 1 | PWM output, active high |

## Verification
The assertions check several properties on every cycle:
- the output is low whenever the block is disabled;
- the tick counter returns to zero after each wrap;
- the working registers hold still at all times except at a period boundary, while disabled, or on a bypass write;
- the output is held high when the high width exceeds the period.

Some behaviours only the bench's scenarios can show. These are the exact clock counts of the high and low phases across a sweep of prescaler, period and width values, and the position of a mid-period commit relative to the old and new waveforms. They also include the default-value selection and the read-back of shadow contents.

// File: rtl/bl_pwm.sv
module bl_pwm #(
  parameter int DIV_W    = 10,
  parameter int PER_W    = 12,
  parameter int HI_W     = 13,
  parameter int DFLT_PER = 7,
  parameter int DFLT_HI  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        pwm_o
);
  localparam logic [2:0] A_EN  = 3'd0;
  localparam logic [2:0] A_C0  = 3'd1;
  localparam logic [2:0] A_C1  = 3'd2;
  localparam logic [2:0] A_CMT = 3'd3;
  localparam logic [2:0] A_DBG = 3'd4;
  localparam int DIV_LSB = 16;
  localparam int HI_LSB  = 16;
  localparam int SEL_BIT = 1;

  logic             en_q, s_sel, s_cmt, pend, w_sel;
  logic [1:0]       s_dbg;
  logic [DIV_W-1:0] s_div, w_div, pcnt;
  logic [PER_W-1:0] s_per, w_per, cnt, per_eff;
  logic [HI_W-1:0]  s_hi, w_hi, hi_eff;
  logic             tick, wrap, byp, bw, ld;

  assign per_eff = w_sel ? w_per : PER_W'(DFLT_PER);
  assign hi_eff  = w_sel ? w_hi  : HI_W'(DFLT_HI);
  assign tick    = en_q && (pcnt >= w_div);
  assign wrap    = tick && (cnt >= per_eff);
  assign byp     = (s_dbg == 2'b11);
  assign bw      = wr_en && byp && (addr == A_C0 || addr == A_C1);
  assign ld      = pend && (!en_q || wrap);
  assign pwm_o   = en_q && (HI_W'(cnt) < hi_eff);

  logic unused_bits;
  assign unused_bits = ^{wdata[31:29], wdata[15:12]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; s_sel <= 1'b0; s_cmt <= 1'b0; pend <= 1'b0; s_dbg <= '0;
      s_div <= '0; s_per <= '0; s_hi <= '0;
      w_div <= '0; w_per <= '0; w_hi <= '0; w_sel <= 1'b0;
    end else begin
      if (ld) begin
        w_div <= s_div; w_per <= s_per; w_hi <= s_hi; w_sel <= s_sel;
        pend  <= 1'b0;
      end
      if (wr_en) begin
        case (addr)
          A_EN: en_q <= wdata[0];
          A_C0: begin
            s_div <= wdata[DIV_LSB +: DIV_W];
            s_sel <= wdata[SEL_BIT];
            if (byp) begin
              w_div <= wdata[DIV_LSB +: DIV_W];
              w_sel <= wdata[SEL_BIT];
            end
          end
          A_C1: begin
            s_per <= wdata[PER_W-1:0];
            s_hi  <= wdata[HI_LSB +: HI_W];
            if (byp) begin
              w_per <= wdata[PER_W-1:0];
              w_hi  <= wdata[HI_LSB +: HI_W];
            end
          end
          A_CMT: begin
            s_cmt <= wdata[0];
            if (wdata[0] && !s_cmt) pend <= 1'b1;
          end
          A_DBG: s_dbg <= wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en_q) begin
      pcnt <= '0;
      cnt  <= '0;
    end else if (tick) begin
      pcnt <= '0;
      cnt  <= wrap ? '0 : cnt + 1'b1;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      rdata <= '0;
      case (addr)
        A_EN:  rdata[0] <= en_q;
        A_C0:  begin
          rdata[DIV_LSB +: DIV_W] <= s_div;
          rdata[SEL_BIT] <= s_sel;
        end
        A_C1:  begin
          rdata[PER_W-1:0] <= s_per;
          rdata[HI_LSB +: HI_W] <= s_hi;
        end
        A_CMT: rdata[0] <= s_cmt;
        A_DBG: rdata[1:0] <= s_dbg;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk #(
  parameter int W     = 36,
  parameter int PER_W = 12,
  parameter int HI_W  = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic             wrap,
  input logic             bw,
  input logic [PER_W-1:0] cnt,
  input logic [PER_W-1:0] per_eff,
  input logic [HI_W-1:0]  hi_eff,
  input logic [W-1:0]     work,
  input logic             pwm_o
);
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !pwm_o); // R4
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && wrap) |=> (cnt == '0)); // R2
  AST_ZERO_WIDTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_eff == '0) |-> !pwm_o); // R3
  AST_WORK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !wrap && !bw) |=> $stable(work)); // R6
  AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && HI_W'(cnt) <= HI_W'(per_eff) && hi_eff > HI_W'(per_eff)) |-> pwm_o); // R9
endmodule

bind bl_pwm bl_pwm_chk #(.W(DIV_W + PER_W + HI_W + 1), .PER_W(PER_W), .HI_W(HI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .wrap(wrap), .bw(bw), .cnt(cnt),
  .per_eff(per_eff), .hi_eff(hi_eff), .work({w_div, w_per, w_hi, w_sel}), .pwm_o(pwm_o)
);

// File: tb/bl_pwm_test.sv
module bl_pwm_test;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic pwm_o;
  int checks = 0, fails = 0, k = 0, cyc = 0;

  bl_pwm uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
              .wdata(wdata), .rdata(rdata), .pwm_o(pwm_o));

  always #2 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at k=%0d", req, act, exp, k);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; k++;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
    addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; k++;
    chk(rdata, exp, req);
  endtask

  function automatic logic [31:0] c1(input int per, input int hi);
    return (32'(hi) << 16) | 32'(per);
  endfunction

  task automatic expect_wave(input int n, input int p, input int h, input int k0, input string req);
    for (int i = 0; i < n; i++) begin
      chk(32'(pwm_o), 32'(((k - k0) % p) < h), req);
      @(negedge clk); k++;
    end
  endtask

  task automatic setup(input int dv, input int sel, input int per, input int hi);
    wr(3'd0, 0);
    wr(3'd1, (32'(dv) << 16) | (32'(sel) << 1));
    wr(3'd2, c1(per, hi));
    wr(3'd3, 1);
    wr(3'd3, 0);
    wr(3'd0, 1);
    k = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk(32'(pwm_o), 0, "R1");
    for (int a = 0; a < 5; a++) rd(3'(a), 0, "R1");

    for (int dv = 0; dv < 3; dv++)
      for (int per = 0; per < 5; per++)
        for (int hi = 0; hi < 7; hi++) begin
          setup(dv, 1, per, hi);
          expect_wave(2 * (dv + 1) * (per + 1), (dv + 1) * (per + 1),
                      (hi > per) ? (dv + 1) * (per + 1) : (dv + 1) * hi, 0,
                      hi == 0 ? "R3" : (hi > per ? "R9" : "R2"));
        end

    setup(1, 0, 3, 1);
    expect_wave(32, 16, 6, 0, "R8");

    setup(1, 1, 3, 2);
    wr(3'd2, c1(3, 0));
    expect_wave(16, 8, 4, 0, "R5");
    rd(3'd2, c1(3, 0), "R10");
    rd(3'd1, (32'd1 << 16) | 32'd2, "R10");

    setup(0, 1, 9, 3);
    wr(3'd2, c1(4, 1));
    wr(3'd3, 1);
    wr(3'd3, 0);
    expect_wave(7, 10, 3, 0, "R6");
    expect_wave(20, 5, 1, 10, "R6");

    setup(0, 1, 9, 5);
    wr(3'd4, 3);
    wr(3'd2, c1(9, 0));
    expect_wave(12, 10, 0, 0, "R7");
    wr(3'd2, c1(9, 20));
    expect_wave(15, 10, 10, 0, "R7");
    wr(3'd4, 0);

    wr(3'd0, 0);
    expect_wave(10, 10, 0, 0, "R4");
    wr(3'd0, 1);
    k = 0;
    expect_wave(12, 10, 10, 0, "R4");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule